// File: doc/BRIEF.md
# MDIO Management Master

This block lets software run Clause 22 management transactions against an external Ethernet PHY. It has a small register window with two 32-bit registers: a command word and a data word. To write a PHY register, software first loads the 16-bit value into the data word. It then writes the command word with the PHY address, the register address, the write flag, the clock divider choice and the start/busy bit set. To read, software writes only the command word. It polls until the busy bit drops, then reads the result from the data word.

While a transaction runs, the block derives the management clock from the system clock by a selectable ratio. It shifts the complete frame out most significant bit first and drives the data line only while the master owns it. On reads, the returned bits are collected on the rising management-clock edges. The command fields are captured when the command is accepted, so any later register activity cannot corrupt a frame in flight.

Top module: `mdio_master`

## Requirements
- R1: After reset the busy bit (command bit 0) reads 0, the data word reads 0, MDC is low and MDIO output enable is 0.
- R2: The command word sits at byte offset 0x48: bit 0 start/busy, bit 1 write (1) or read (0), bits [8:4] PHY register address, bits [16:12] PHY address, bits [21:20] divider select. It reads back the stored fields and the live busy bit, with all other bits 0. A command written with bit 0 clear only stores its fields and starts nothing.
- R3: Writing the command word with bit 0 set while idle sets busy. Busy clears exactly 64*N system cycles after the accepting clock edge, where N is the MDC period.
- R4: The MDC period is N = 16 << sel system cycles, where sel is command bits [21:20] (0:/16, 1:/32, 2:/64, 3:/128). MDC is low for the first half of each period and high for the second half.
- R5: A write frame is 32 ones, start 01, opcode 01, five PHY address bits, five register bits, turnaround 10, then 16 data bits, all MSB first. Exactly one frame bit is driven per MDC period.
- R6: A read frame carries opcode 10. The master drives the first 46 bits and releases MDIO (output enable 0) from the first turnaround bit until the end of the frame.
- R7: On a read, the master samples MDIO on the rising MDC edge of each of the last 16 bits. When busy clears, the data word (offset 0x4C) holds those bits in its low 16 bits, MSB first, with the upper bits 0.
- R8: A command write while busy is set is ignored. The running frame continues unchanged, the busy time is unchanged, and the stored fields are unchanged.
- R9: MDIO output changes only on falling MDC edges during a frame. When idle, MDC stays low and MDIO is released.
- R10: The data word at 0x4C reads back what software wrote. The write payload comes from its low 16 bits as they stand when the command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives the line) |

## Verification
The assertions check the following on every cycle: MDC stays low and MDIO is released when idle, and MDIO output moves only on falling MDC edges. The line is also released through the whole read turnaround and data phase, each MDC high phase lasts its selected length, the end of a frame drops busy, and a command written while busy leaves the stored fields alone. Some properties need a PHY on the other end and exact arithmetic, so only the bench scenarios can show them. These are the bit-exact frame content, the read value landing in the data word, the total busy time per divider, and the round trip through a modelled PHY register file over several addresses and all four dividers.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DIV_W         = 2;
  localparam int MDC_BASE_HALF = 8;
  localparam int HALF_MAX      = MDC_BASE_HALF << ((1 << DIV_W) - 1);
  localparam int HALF_W        = $clog2(HALF_MAX) + 1;
  localparam int FRAME_BITS    = 64;
  localparam int IDX_W         = $clog2(FRAME_BITS);
  localparam int TA_IDX        = 46;
  localparam int RD_IDX        = 48;
  localparam int PHY_DATA_W    = 16;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [4:0]       phy;
    logic [4:0]       regad;
    logic             wr;
  } mdio_cmd_t;

  function automatic logic [HALF_W-1:0] mdc_half(input logic [DIV_W-1:0] sel);
    return HALF_W'(MDC_BASE_HALF) << sel;
  endfunction

  function automatic mdio_cmd_t cmd_decode(input logic [31:0] w);
    mdio_cmd_t c;
    c.wr    = w[1];
    c.regad = w[8:4];
    c.phy   = w[16:12];
    c.div   = w[21:20];
    return c;
  endfunction

  function automatic logic [31:0] cmd_encode(input mdio_cmd_t c, input logic busy);
    logic [31:0] w;
    w        = '0;
    w[0]     = busy;
    w[1]     = c.wr;
    w[8:4]   = c.regad;
    w[16:12] = c.phy;
    w[21:20] = c.div;
    return w;
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c,
                                                        input logic [PHY_DATA_W-1:0] d);
    logic [1:0] op;
    logic [1:0] ta;
    op = c.wr ? 2'b01 : 2'b10;
    ta = c.wr ? 2'b10 : 2'b11;
    return {{32{1'b1}}, 2'b01, op, c.phy, c.regad, ta, d};
  endfunction
endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter logic [7:0]  CMD_OFF  = 8'h48,
  parameter logic [7:0]  DATA_OFF = 8'h4C
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic                  done,
  input  logic                  done_read,
  input  logic [PHY_DATA_W-1:0] rx_data,
  output logic                  start,
  output mdio_cmd_t             start_cmd,
  output mdio_cmd_t             cmd_q,
  output logic                  busy,
  output logic                  cmd_attempt,
  output logic [PHY_DATA_W-1:0] payload
);
  logic              cmd_hit;
  logic              data_hit;
  logic [DATA_W-1:0] data_q;

  assign cmd_hit     = (bus_addr == ADDR_W'(CMD_OFF));
  assign data_hit    = (bus_addr == ADDR_W'(DATA_OFF));
  assign cmd_attempt = bus_wr && cmd_hit;
  assign start       = cmd_attempt && bus_wdata[0] && !busy;
  assign start_cmd   = cmd_decode(32'(bus_wdata));
  assign payload     = data_q[PHY_DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      busy   <= 1'b0;
      data_q <= '0;
    end else begin
      if (cmd_attempt && !busy) cmd_q <= start_cmd;
      if (start)      busy <= 1'b1;
      else if (done)  busy <= 1'b0;
      if (done && done_read)       data_q <= DATA_W'(rx_data);
      else if (bus_wr && data_hit) data_q <= bus_wdata;
    end
  end

  always_comb begin
    if (cmd_hit)       bus_rdata = DATA_W'(cmd_encode(cmd_q, busy));
    else if (data_hit) bus_rdata = data_q;
    else               bus_rdata = '0;
  end
endmodule

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              mdc,
  output logic              rise_evt,
  output logic              fall_evt
);
  logic [HALF_W-1:0] cnt;
  logic              wrap;

  assign wrap     = run && (cnt == half - HALF_W'(1));
  assign rise_evt = wrap && !mdc;
  assign fall_evt = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + HALF_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  mdio_cmd_t             start_cmd,
  input  logic [PHY_DATA_W-1:0] payload,
  input  logic                  rise_evt,
  input  logic                  fall_evt,
  input  logic                  mdio_i,
  output logic                  active,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  done,
  output logic                  is_write,
  output logic [DIV_W-1:0]      div_sel,
  output logic [IDX_W-1:0]      bit_idx,
  output logic [PHY_DATA_W-1:0] rx_data
);
  logic [FRAME_BITS-1:0] shreg;
  logic                  last_bit;
  logic                  in_rx_window;

  assign last_bit     = (bit_idx == IDX_W'(FRAME_BITS - 1));
  assign done         = active && fall_evt && last_bit;
  assign in_rx_window = (bit_idx >= IDX_W'(RD_IDX));
  assign mdio_o       = active ? shreg[FRAME_BITS-1] : 1'b1;
  assign mdio_oe      = active && (is_write || (bit_idx < IDX_W'(TA_IDX)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      shreg    <= '0;
      bit_idx  <= '0;
      is_write <= 1'b0;
      div_sel  <= '0;
      rx_data  <= '0;
    end else if (start) begin
      active   <= 1'b1;
      shreg    <= build_frame(start_cmd, payload);
      bit_idx  <= '0;
      is_write <= start_cmd.wr;
      div_sel  <= start_cmd.div;
    end else if (active) begin
      if (rise_evt && !is_write && in_rx_window)
        rx_data <= {rx_data[PHY_DATA_W-2:0], mdio_i};
      if (fall_evt) begin
        if (last_bit) begin
          active <= 1'b0;
        end else begin
          bit_idx <= bit_idx + IDX_W'(1);
          shreg   <= {shreg[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 32,
  parameter logic [7:0] CMD_OFF  = 8'h48,
  parameter logic [7:0] DATA_OFF = 8'h4C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic                  start;
  mdio_cmd_t             start_cmd;
  mdio_cmd_t             cmd_q;
  logic                  busy;
  logic                  cmd_attempt;
  logic [PHY_DATA_W-1:0] payload;
  logic                  done;
  logic                  active;
  logic                  is_write;
  logic [DIV_W-1:0]      div_sel;
  logic [IDX_W-1:0]      bit_idx;
  logic [PHY_DATA_W-1:0] rx_data;
  logic                  rise_evt;
  logic                  fall_evt;
  logic [HALF_W-1:0]     half;

  assign half = mdc_half(div_sel);

  mdio_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_OFF(CMD_OFF), .DATA_OFF(DATA_OFF)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done(done),
    .done_read(!is_write), .rx_data(rx_data), .start(start),
    .start_cmd(start_cmd), .cmd_q(cmd_q), .busy(busy),
    .cmd_attempt(cmd_attempt), .payload(payload)
  );

  mdio_mdc_gen u_mdc (
    .clk(clk), .rst_n(rst_n), .run(active), .half(half),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .start_cmd(start_cmd),
    .payload(payload), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .mdio_i(mdio_i), .active(active), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done), .is_write(is_write), .div_sel(div_sel), .bit_idx(bit_idx),
    .rx_data(rx_data)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             active,
  input logic             done,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             is_write,
  input logic [DIV_W-1:0] div_sel,
  input logic [IDX_W-1:0] bit_idx,
  input logic             cmd_attempt,
  input mdio_cmd_t        cmd_q
);
  logic [HALF_W:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_len <= '0;
    else if (mdc) hi_len <= hi_len + 1'b1;
    else          hi_len <= '0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc)); // R9
  AST_MDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$stable(mdio_o)) |-> $fell(mdc)); // R9
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !is_write && bit_idx >= IDX_W'(TA_IDX)) |-> !mdio_oe); // R6
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R3
  AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_attempt) |=> $stable(cmd_q)); // R8
  AST_MDC_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> (hi_len == (HALF_W+1)'(mdc_half(div_sel)))); // R4
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .active(active), .done(done),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .is_write(is_write),
  .div_sel(div_sel), .bit_idx(bit_idx), .cmd_attempt(cmd_attempt),
  .cmd_q(cmd_q)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;
  localparam logic [7:0] CMD  = 8'h48;
  localparam logic [7:0] DATW = 8'h4C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        phy_drv = 1'b0;
  logic        phy_bit = 1'b1;
  wire         line = mdio_oe ? mdio_o : (phy_drv ? phy_bit : 1'b1);

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [15:0] phyregs [32][32];

  always #2 clk = !clk;

  mdio_master i_mdio_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_i(line), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cmdw(input bit wr, input logic [1:0] sel,
                                       input logic [4:0] p, input logic [4:0] r,
                                       input bit go);
    return (32'(sel) << 20) | (32'(p) << 12) | (32'(r) << 4) | (32'(wr) << 1) | 32'(go);
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic xfer(input bit wr, input logic [1:0] sel, input logic [4:0] p,
                      input logic [4:0] r, input logic [15:0] wd, input bit inject);
    logic [63:0] f, ex;
    logic [15:0] rv, want;
    realtime t1, t2;
    int cnt;
    bit relok;
    f = '1; rv = '0; t1 = 0; t2 = 0; cnt = 0; relok = 1;
    want = phyregs[p][r];
    if (wr) bus_write(DATW, 32'(wd));
    bus_write(CMD, cmdw(wr, sel, p, r, 1'b1));
    fork
      begin
        for (int k = 0; k < 64; k++) begin
          @(posedge mdc);
          if (k == 1) t1 = $realtime;
          if (k == 2) t2 = $realtime;
          f[63-k] = line;
          if (!wr && k >= 46 && mdio_oe) relok = 0;
          if (!wr && k >= 46 && k < 63) begin
            if (k == 46) rv = phyregs[f[27:23]][f[22:18]];
            @(negedge mdc);
            phy_drv = 1'b1;
            phy_bit = (k == 46) ? 1'b0 : rv[62-k];
          end
        end
      end
      begin
        bus_addr = CMD;
        while (bus_rdata[0]) begin
          @(negedge clk); cnt++;
          if (inject && cnt == 100) begin
            bus_wdata = cmdw(!wr, ~sel, ~p, ~r, 1'b1); bus_wr = 1'b1;
            @(negedge clk); bus_wr = 1'b0; cnt++;
          end
        end
      end
    join
    phy_drv = 1'b0;
    ex = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), p, r, 2'b10, wd};
    chk(cnt == 64 * (16 << sel), "R3 busy time", 64'(cnt), 64'(64 * (16 << sel)));
    chk((t2 - t1) == 4.0 * (16 << sel), "R4 mdc period",
        64'(int'(t2 - t1)), 64'(4 * (16 << sel)));
    if (wr) begin
      chk(f == ex, inject ? "R8 frame after ignored cmd" : "R5 write frame", f, ex);
      phyregs[f[27:23]][f[22:18]] = f[15:0];
    end else begin
      chk(f[63:18] == ex[63:18], "R6 read frame header", 64'(f[63:18]), 64'(ex[63:18]));
      chk(relok, "R6 line released in turnaround/data", 64'(relok), 64'd1);
      bus_addr = DATW; #1;
      chk(bus_rdata == 32'(want), "R7 read data captured", 64'(bus_rdata), 64'(want));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 32; p++)
      for (int r = 0; r < 32; r++)
        phyregs[p][r] = 16'(p * 16'h0913) ^ 16'(r * 16'h1357) ^ 16'hA5C3;
    repeat (3) @(negedge clk);
    // R1: reset values
    bus_addr = CMD; #1;
    chk(bus_rdata == 32'd0, "R1 cmd after reset", 64'(bus_rdata), 64'd0);
    bus_addr = DATW; #1;
    chk(bus_rdata == 32'd0, "R1 data after reset", 64'(bus_rdata), 64'd0);
    chk(!mdc && !mdio_oe, "R1 mdc low, line released", {mdc, mdio_oe}, 64'd0);
    rst_n = 1'b1;
    // R2: field readback without start
    bus_write(CMD, cmdw(1'b1, 2'd2, 5'd21, 5'd10, 1'b0) | 32'hFC0C_0E0C);
    bus_addr = CMD; #1;
    chk(bus_rdata == cmdw(1'b1, 2'd2, 5'd21, 5'd10, 1'b0), "R2 command readback",
        64'(bus_rdata), 64'(cmdw(1'b1, 2'd2, 5'd21, 5'd10, 1'b0)));
    repeat (40) @(negedge clk);
    chk(!mdc && !mdio_oe, "R9 idle after non-start command", {mdc, mdio_oe}, 64'd0);
    // R10: data word readback
    bus_write(DATW, 32'hDEAD_BEEF);
    bus_addr = DATW; #1;
    chk(bus_rdata == 32'hDEAD_BEEF, "R10 data readback", 64'(bus_rdata), 64'hDEAD_BEEF);
    // every divider: write then read back through the PHY model
    for (int s = 0; s < 4; s++) begin
      xfer(1'b1, 2'(s), 5'(s * 7 + 1), 5'(s * 5 + 2), 16'(16'h1234 * (s + 3)), 1'b0);
      chk(phyregs[5'(s * 7 + 1)][5'(s * 5 + 2)] == 16'(16'h1234 * (s + 3)),
          "R10 payload reached PHY", 64'(phyregs[5'(s * 7 + 1)][5'(s * 5 + 2)]),
          64'(16'(16'h1234 * (s + 3))));
      xfer(1'b0, 2'(s), 5'(s * 7 + 1), 5'(s * 5 + 2), 16'h0, 1'b0);
    end
    // read sweep over addresses at the fastest divider
    for (int i = 0; i < 10; i++)
      xfer(1'b0, 2'd0, 5'(i * 3 + 4), 5'(31 - i * 3), 16'h0, 1'b0);
    // R8: command written mid-frame is ignored
    xfer(1'b1, 2'd0, 5'd9, 5'd17, 16'h5AA5, 1'b1);
    bus_addr = CMD; #1;
    chk(bus_rdata == cmdw(1'b1, 2'd0, 5'd9, 5'd17, 1'b0), "R8 fields kept",
        64'(bus_rdata), 64'(cmdw(1'b1, 2'd0, 5'd9, 5'd17, 1'b0)));
    repeat (40) @(negedge clk);
    chk(!mdc && !mdio_oe, "R9 idle after frame", {mdc, mdio_oe}, 64'd0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule